// File: doc/BRIEF.md
# Embedded Sync Decoder for 4:2:2 Component Video

This block takes a 10-bit multiplexed 4:2:2 luma/chroma word stream, one word per pixel clock, in which all line and field timing travels inside the data. Each line is framed by timing reference codes. A code is three fixed words (all ones, zero, zero) followed by a flag word. That word carries field, vertical-blank and horizontal-position bits, together with four protection bits computed from them. No external sync pins are used. The block finds the codes, checks their protection bits and keeps the last trusted flags. From these it produces horizontal blanking, vertical blanking, field and active-video signals.

During active video each word is tagged with its place in the repeating chroma-blue, luma, chroma-red, luma group. Every complete group is also handed out as one parallel sample pair. Two control inputs select the line length and the scan mode. One picks a 720-pixel or a 710-pixel active line. The other selects non-interlaced operation, which forces the field output low.

Top module: `embsync_decoder`

## Requirements
- R1: While rst_n is low, every output is zero.
- R2: A flag word that follows the words 0x3FF, 0x000, 0x000 and is valid raises code_ok for the single cycle after the edge that samples it. Valid means bit 9 is 1 and the protection bits match the rule in R4.
- R3: On a valid code, the field, vertical and horizontal bits (flag word bits 8, 7 and 6) are stored. hblank shows the stored horizontal bit and vblank shows the stored vertical bit from the next cycle on.
- R4: Flag word bits 5..2 must equal V^H, F^H, F^V and F^V^H. If they do not, or if bit 9 is 0, code_err pulses for one cycle and the stored flags keep their previous values.
- R5: With noninterlaced low, field shows the stored field bit. From the edge after noninterlaced is high, field is 0.
- R6: After a valid code with horizontal bit 0 and vertical bit 0, active rises together with the next word. That word carries phase 0. Phase then steps 0,1,2,3 (chroma blue, luma, chroma red, luma) and wraps.
- R7: A word equal to 0x3FF ends the active window, and no word of a timing code is ever marked active.
- R8: At most 1440 words (short_line=0) or 1420 words (short_line=1) are marked active after a start code.
- R9: A start code with vertical bit 1, or one with bad protection, does not open an active window.
- R10: One cycle after the phase-3 word of a group is presented as active, pair_valid pulses for one cycle. During that cycle pair_cb, pair_y0, pair_cr and pair_y1 hold the four words of the group.
- R11: vid_word repeats din with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 10 | Multiplexed video word |
| short_line | input | 1 | 1 selects the 710-pixel active line, 0 the 720-pixel line |
| noninterlaced | input | 1 | 1 holds the field output at zero |
| code_ok | output | 1 | Pulse: valid timing code received |
| code_err | output | 1 | Pulse: timing code with failed protection |
| hblank | output | 1 | Stored horizontal flag |
| vblank | output | 1 | Stored vertical flag |
| field | output | 1 | Stored field flag, gated by scan mode |
| active | output | 1 | Current vid_word is active video |
| phase | output | 2 | Position of vid_word in its four-word group |
| vid_word | output | 10 | Registered video word |
| pair_valid | output | 1 | Pulse: a full four-word group is on the pair outputs |
| pair_cb | output | 10 | Chroma-blue word of the group |
| pair_y0 | output | 10 | First luma word of the group |
| pair_cr | output | 10 | Chroma-red word of the group |
| pair_y1 | output | 10 | Second luma word of the group |

## Verification
The following results all appear one edge after the word that causes them is sampled: the code flags, the stored hblank/vblank/field, vid_word and the active/phase tag of each word. The first active word is the one sampled right after the flag word. A sample pair appears one edge later than the tag of its phase-3 word, which is two edges after that word entered. The bench changes din on the falling edge and reads every output at the next falling edge. Its model of the requirements advances exactly one word per step and keeps the previous step's tag to predict the pair, so each comparison lands on the cycle where the result is due.

// File: rtl/embsync_pkg.sv
package embsync_pkg;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_flags_t;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_t;

  // protection nibble for a flag set, MSB first
  function automatic logic [3:0] trs_parity(input trs_flags_t fl);
    return {fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
  endfunction

  // upper eight bits of the flag word: 1, F, V, H, P3..P0
  function automatic logic xy_byte_ok(input logic [7:0] xy);
    return xy[7] && (xy[3:0] == trs_parity(trs_flags_t'(xy[6:4])));
  endfunction

  function automatic int unsigned act_words(input logic sel_short,
                                            input int unsigned long_pix,
                                            input int unsigned short_pix);
    return sel_short ? 2 * short_pix : 2 * long_pix;
  endfunction

endpackage

// File: rtl/embsync_trs_detect.sv
module embsync_trs_detect
  import embsync_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic          xy_hit,
  output logic          xy_good,
  output trs_flags_t    xy_flags,
  output logic          code_ok_q,
  output logic          code_err_q,
  output trs_flags_t    flags_q
);

  logic [DW-1:0] h1, h2, h3;
  logic [7:0]    xy_byte;

  assign xy_byte  = din[DW-1 -: 8];
  assign xy_hit   = (h3 == '1) && (h2 == '0) && (h1 == '0);
  assign xy_flags = trs_flags_t'(xy_byte[6:4]);
  assign xy_good  = xy_hit && xy_byte_ok(xy_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h1         <= '0;
      h2         <= '0;
      h3         <= '0;
      code_ok_q  <= 1'b0;
      code_err_q <= 1'b0;
      flags_q    <= '0;
    end else begin
      h3         <= h2;
      h2         <= h1;
      h1         <= din;
      code_ok_q  <= xy_good;
      code_err_q <= xy_hit && !xy_good;
      if (xy_good) flags_q <= xy_flags;
    end
  end

  AST_OK_AFTER_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok_q |-> ($past(h3) == '1) && ($past(h2) == '0) && ($past(h1) == '0)); // R2
  AST_OK_LOADS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok_q |-> flags_q == trs_flags_t'($past(din[DW-2 -: 3]))); // R3
  AST_ERR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    code_err_q |-> flags_q == $past(flags_q)); // R4

endmodule

// File: rtl/embsync_line_window.sv
module embsync_line_window
  import embsync_pkg::*;
#(
  parameter int DW            = 10,
  parameter int ACT_LONG_PIX  = 720,
  parameter int ACT_SHORT_PIX = 710
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          xy_hit,
  input  logic          xy_good,
  input  trs_flags_t    xy_flags,
  input  logic          short_line,
  output logic          active_q,
  output phase_t        phase_q,
  output logic [DW-1:0] word_q
);

  localparam int LONG_W = 2 * ACT_LONG_PIX;
  localparam int CW     = $clog2(LONG_W + 1);

  logic          arm_q;
  logic [CW-1:0] wcnt_q;
  logic          is_pre;
  logic          limit_hit;

  assign is_pre    = (din == '1);
  assign limit_hit = (wcnt_q == CW'(act_words(short_line, ACT_LONG_PIX, ACT_SHORT_PIX)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q    <= 1'b0;
      wcnt_q   <= '0;
      active_q <= 1'b0;
      phase_q  <= PH_CB;
      word_q   <= '0;
    end else begin
      word_q <= din;
      arm_q  <= xy_good && !xy_flags.h && !xy_flags.v;
      if (xy_hit) begin
        active_q <= 1'b0;
      end else if (arm_q) begin
        active_q <= !is_pre;
        wcnt_q   <= CW'(1);
        phase_q  <= PH_CB;
      end else if (active_q) begin
        if (is_pre || limit_hit) begin
          active_q <= 1'b0;
        end else begin
          wcnt_q  <= wcnt_q + CW'(1);
          phase_q <= phase_t'(phase_q + 2'd1);
        end
      end
    end
  end

  AST_START_ON_CB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> phase_q == PH_CB); // R6
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && $past(active_q) |-> phase_q == phase_t'($past(phase_q) + 2'd1)); // R6
  AST_CODE_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(din == '1) |-> !active_q); // R7
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> wcnt_q <= CW'(LONG_W)); // R8

endmodule

// File: rtl/embsync_pair_split.sv
module embsync_pair_split
  import embsync_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  phase_t        phase,
  input  logic [DW-1:0] word,
  output logic          pair_valid_q,
  output logic [DW-1:0] cb_q,
  output logic [DW-1:0] y0_q,
  output logic [DW-1:0] cr_q,
  output logic [DW-1:0] y1_q
);

  logic [DW-1:0] cb_h, y0_h, cr_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb_h         <= '0;
      y0_h         <= '0;
      cr_h         <= '0;
      pair_valid_q <= 1'b0;
      cb_q         <= '0;
      y0_q         <= '0;
      cr_q         <= '0;
      y1_q         <= '0;
    end else begin
      pair_valid_q <= 1'b0;
      if (active) begin
        case (phase)
          PH_CB: cb_h <= word;
          PH_Y0: y0_h <= word;
          PH_CR: cr_h <= word;
          default: begin
            pair_valid_q <= 1'b1;
            cb_q         <= cb_h;
            y0_q         <= y0_h;
            cr_q         <= cr_h;
            y1_q         <= word;
          end
        endcase
      end
    end
  end

  AST_PAIR_AFTER_Y1: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_q |-> $past(active && phase == PH_Y1)); // R10

endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder
  import embsync_pkg::*;
#(
  parameter int DW            = 10,
  parameter int ACT_LONG_PIX  = 720,
  parameter int ACT_SHORT_PIX = 710
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          short_line,
  input  logic          noninterlaced,
  output logic          code_ok,
  output logic          code_err,
  output logic          hblank,
  output logic          vblank,
  output logic          field,
  output logic          active,
  output logic [1:0]    phase,
  output logic [DW-1:0] vid_word,
  output logic          pair_valid,
  output logic [DW-1:0] pair_cb,
  output logic [DW-1:0] pair_y0,
  output logic [DW-1:0] pair_cr,
  output logic [DW-1:0] pair_y1
);

  logic       xy_hit, xy_good;
  trs_flags_t xy_flags, flags_q;
  phase_t     phase_w;
  logic       field_q;

  embsync_trs_detect #(.DW(DW)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .xy_hit     (xy_hit),
    .xy_good    (xy_good),
    .xy_flags   (xy_flags),
    .code_ok_q  (code_ok),
    .code_err_q (code_err),
    .flags_q    (flags_q)
  );

  embsync_line_window #(
    .DW            (DW),
    .ACT_LONG_PIX  (ACT_LONG_PIX),
    .ACT_SHORT_PIX (ACT_SHORT_PIX)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .xy_hit     (xy_hit),
    .xy_good    (xy_good),
    .xy_flags   (xy_flags),
    .short_line (short_line),
    .active_q   (active),
    .phase_q    (phase_w),
    .word_q     (vid_word)
  );

  embsync_pair_split #(.DW(DW)) u_pair (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active),
    .phase        (phase_w),
    .word         (vid_word),
    .pair_valid_q (pair_valid),
    .cb_q         (pair_cb),
    .y0_q         (pair_y0),
    .cr_q         (pair_cr),
    .y1_q         (pair_y1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) field_q <= 1'b0;
    else        field_q <= !noninterlaced && (xy_good ? xy_flags.f : flags_q.f);
  end

  assign phase  = phase_w;
  assign hblank = flags_q.h;
  assign vblank = flags_q.v;
  assign field  = field_q;

  AST_FIELD_NONINT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(noninterlaced) |-> !field_q); // R5

endmodule

// File: tb/test_embsync_decoder.sv
`timescale 1ns/1ps
module test_embsync_decoder;

  logic       clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, short_line, noninterlaced;
  logic [9:0] din;
  logic       code_ok, code_err, hblank, vblank, field, active, pair_valid;
  logic [1:0] phase;
  logic [9:0] vid_word, pair_cb, pair_y0, pair_cr, pair_y1;

  embsync_decoder i_embsync_decoder (
    .clk(clk), .rst_n(rst_n), .din(din), .short_line(short_line),
    .noninterlaced(noninterlaced), .code_ok(code_ok), .code_err(code_err),
    .hblank(hblank), .vblank(vblank), .field(field), .active(active),
    .phase(phase), .vid_word(vid_word), .pair_valid(pair_valid),
    .pair_cb(pair_cb), .pair_y0(pair_y0), .pair_cr(pair_cr), .pair_y1(pair_y1)
  );

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string ctx   = "";

  // requirement model state
  logic [9:0] m_h1 = 0, m_h2 = 0, m_h3 = 0, m_word = 0;
  logic       m_f = 0, m_v = 0, m_h = 0, m_field = 0, m_ok = 0, m_err = 0;
  logic       m_arm = 0, m_act = 0, m_pv = 0;
  int         m_cnt = 0, m_ph = 0;
  logic [9:0] m_cb = 0, m_y0 = 0, m_cr = 0, m_pcb = 0, m_py0 = 0, m_pcr = 0, m_py1 = 0;

  function automatic logic [9:0] mk_xy(bit f, bit v, bit h, bit corrupt);
    logic [3:0] p;
    p = {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    if (corrupt) p = p ^ 4'b0010;
    return {1'b1, f, v, h, p, 2'b00};
  endfunction

  function automatic int max_words(bit s);
    return s ? 1420 : 1440;
  endfunction

  function automatic logic [9:0] rnd_word();
    return 10'($urandom_range(1022, 1));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ctx, act, exp);
    end
  endtask

  task automatic model_step(input logic [9:0] w);
    bit hit, good;
    hit  = (m_h3 == 10'h3FF) && (m_h2 == 10'h000) && (m_h1 == 10'h000);
    good = hit && w[9] && (w[5:2] == {w[7] ^ w[6], w[8] ^ w[6], w[8] ^ w[7], w[8] ^ w[7] ^ w[6]});
    m_pv = 0;
    if (m_act) begin
      case (m_ph)
        0: m_cb = m_word;
        1: m_y0 = m_word;
        2: m_cr = m_word;
        default: begin
          m_pv = 1; m_pcb = m_cb; m_py0 = m_y0; m_pcr = m_cr; m_py1 = m_word;
        end
      endcase
    end
    if (hit) m_act = 0;
    else if (m_arm) begin
      m_act = (w != 10'h3FF); m_cnt = 1; m_ph = 0;
    end else if (m_act) begin
      if (w == 10'h3FF || m_cnt == max_words(short_line)) m_act = 0;
      else begin m_cnt++; m_ph = (m_ph + 1) % 4; end
    end
    m_arm = good && !w[6] && !w[7];
    m_ok  = good;
    m_err = hit && !good;
    if (good) {m_f, m_v, m_h} = w[8:6];
    m_field = noninterlaced ? 1'b0 : m_f;
    m_word  = w;
    m_h3 = m_h2; m_h2 = m_h1; m_h1 = w;
  endtask

  task automatic send(input logic [9:0] w);
    din = w;
    model_step(w);
    @(negedge clk);
    chk("R11 vid_word", vid_word, m_word);
    chk("R2 code_ok", code_ok, m_ok);
    chk("R4 code_err", code_err, m_err);
    chk("R3 hblank", hblank, m_h);
    chk("R3 vblank", vblank, m_v);
    chk("R5 field", field, m_field);
    chk("R6/R7/R8/R9 active", active, m_act);
    if (m_act) chk("R6 phase", phase, m_ph[1:0]);
    chk("R10 pair_valid", pair_valid, m_pv);
    if (m_pv) begin
      chk("R10 pair_cb", pair_cb, m_pcb);
      chk("R10 pair_y0", pair_y0, m_py0);
      chk("R10 pair_cr", pair_cr, m_pcr);
      chk("R10 pair_y1", pair_y1, m_py1);
    end
  endtask

  task automatic send_code(input bit f, input bit v, input bit h, input bit corrupt);
    send(10'h3FF); send(10'h000); send(10'h000); send(mk_xy(f, v, h, corrupt));
  endtask

  task automatic send_line(input bit f, input bit v, input int nblank, input int nact,
                           input bit bad_eav, input bit bad_sav);
    send_code(f, v, 1'b1, bad_eav);
    for (int i = 0; i < nblank; i++) send(rnd_word());
    send_code(f, v, 1'b0, bad_sav);
    for (int i = 0; i < nact; i++) send(rnd_word());
  endtask

  initial begin
    void'($urandom(32'd7311));
    rst_n = 0; din = 0; short_line = 0; noninterlaced = 0;
    repeat (3) @(negedge clk);
    ctx = "R1 reset";
    chk("R1 code_ok", code_ok, 0);   chk("R1 code_err", code_err, 0);
    chk("R1 hblank", hblank, 0);     chk("R1 vblank", vblank, 0);
    chk("R1 field", field, 0);       chk("R1 active", active, 0);
    chk("R1 vid_word", vid_word, 0); chk("R1 pair_valid", pair_valid, 0);
    chk("R1 pair_y1", pair_y1, 0);
    rst_n = 1;

    ctx = "R2 R3 R6 basic line";   send_line(0, 0, 8, 16, 0, 0);
    ctx = "R3 field one";          send_line(1, 0, 6, 10, 0, 0);
    ctx = "R8 exact 720";          short_line = 0; send_line(0, 0, 4, 1440, 0, 0);
    ctx = "R8 overrun long";       send_line(0, 0, 4, 1452, 0, 0);
    ctx = "R8 overrun short";      short_line = 1; send_line(1, 0, 4, 1430, 0, 0);
    ctx = "R8 exact short";        send_line(0, 0, 4, 1420, 0, 0);
    short_line = 0;
    ctx = "R9 vblank start";       send_line(0, 1, 5, 12, 0, 0);
    ctx = "R4 R9 bad start code";  send_line(1, 0, 5, 12, 0, 1);
    ctx = "R4 bad end code";       send_line(0, 0, 5, 9, 1, 0);
    ctx = "R5 noninterlaced";      noninterlaced = 1; send_line(1, 0, 3, 8, 0, 0);
    ctx = "R5 back interlaced";    noninterlaced = 0; send_line(1, 0, 3, 8, 0, 0);
    ctx = "R7 code after short active"; send_line(0, 0, 2, 3, 0, 0);

    ctx = "random lines R2 R4 R6 R7";
    for (int k = 0; k < 40; k++) begin
      short_line    = ($urandom_range(3, 0) == 0);
      noninterlaced = ($urandom_range(4, 0) == 0);
      send_line($urandom_range(1, 0), ($urandom_range(3, 0) == 0),
                $urandom_range(40, 1), $urandom_range(300, 1),
                ($urandom_range(5, 0) == 0), ($urandom_range(5, 0) == 0));
    end
    ctx = "tail";
    send_code(0, 1, 1, 0);
    send(rnd_word());

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule